// File: doc/BRIEF.md
# PCI Target Address-Phase Decoder

This block runs next to the state machine of a PCI target. It watches the shared bus for the start of each transaction. On the one clock edge that carries the address and command, it stores AD, C/BE#, IDSEL and the memory-space enable. The decision on whether this target is being addressed is then made from those stored copies, one clock later. It is never made from the live AD lines, which by then carry data.

Because decoding relies only on the captured values, a configuration access still gets claimed when FRAME# is low for a single clock. The same holds for any other access whose address is gone after the first edge. The block reports a memory-space hit, a configuration hit and a next-state recommendation for the target controller. The recommendation has three values: stay idle, track a transaction that belongs to another agent, or claim the access.

Top module: `pci_addr_decoder`

## Requirements
- R1: While reset is low, and after it is released with the bus idle, `rec_o` is 00 (idle), both hit outputs are 0, and `addr_o` and `cmd_o` are 0.
- R2: A clock edge is an address phase when it samples FRAME# low and the previous edge sampled both FRAME# and IRDY# high. At that edge AD, C/BE#, IDSEL and the memory enable are stored. `addr_o` and `cmd_o` show the stored AD and C/BE# after that edge and hold them until the next address phase.
- R3: `cfg_hit_o` becomes 1 only if all three of these held in the address phase: IDSEL was high, the command was 1010 or 1011, and AD[1:0] was 00. It does not depend on the BAR or on the memory enable.
- R4: `mem_hit_o` becomes 1 only if all three of these hold. The command is one of 0110, 0111, 1100, 1110 or 1111. The memory enable was 1 in the address phase. The stored address equals `bar_base` on bits [31:BAR_SIZE_LOG2], with the default BAR_SIZE_LOG2 = 12.
- R5: Hit outputs and `rec_o` change at the edge after the address phase. In the clock between the address phase and that edge, `rec_o` is 00 and both hits are 0.
- R6: From that edge on, `rec_o` is 10 (claim) when either hit is 1, and 01 (busy for another agent) when neither is.
- R7: Hits and `rec_o` hold their values until an edge samples FRAME# and IRDY# both high. After that edge, `rec_o` is 00 and both hits are 0.
- R8: FRAME# sampled low when the previous edge did not see an idle bus is not an address phase. Data words on AD, changes of C/BE#, IDSEL or memory enable during data phases leave `addr_o`, `cmd_o` and the decode unchanged.
- R9: An access whose FRAME# is low for exactly one clock decodes the same as a longer one.
- R10: A new transaction that starts after exactly one idle clock is recognised and decoded on its own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| idsel | input | 1 | Configuration select for this device |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command / byte enables |
| bar_base | input | 32 | Base address register, held stable during a transaction |
| mem_space_en | input | 1 | Memory-space enable bit of the command register |
| addr_o | output | 32 | Address captured in the last address phase |
| cmd_o | output | 4 | Command captured in the last address phase |
| mem_hit_o | output | 1 | Access falls in this target's memory window |
| cfg_hit_o | output | 1 | Configuration access addressed to this target |
| rec_o | output | 2 | Recommendation: 00 idle, 01 busy, 10 claim |

## Verification
The hardest situation to reach is one where the only valid address sits on AD for a single edge. After that edge FRAME# is already high and the AD, C/BE#, IDSEL and enable lines carry unrelated values. A decoder that looks at the live bus fails here. The stimulus recreates this on every transaction: from the first data phase on, it scrambles all those inputs with random values. It also includes directed single-clock configuration reads with IDSEL high, and transactions chained with exactly one idle clock between them, so the idle-to-address-phase rule is exercised at its tightest spacing.

// File: rtl/pci_adec_pkg.sv
// Package: shared types and command classification for the PCI
// address-phase decoder. Assumes C/BE# carries the command code
// unchanged during the address phase.
package pci_adec_pkg;

    // Recommendation handed to the target controller.
    typedef enum logic [1:0] {
        REC_IDLE    = 2'b00,
        REC_BUSY    = 2'b01,
        REC_DECODED = 2'b10
    } rec_e;

    // Internal tracking state of the decoder.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_LATCHED = 2'b01,
        ST_BUSY    = 2'b10,
        ST_CLAIMED = 2'b11
    } state_e;

    // True for command codes that address memory space.
    function automatic logic is_mem_cmd(input logic [3:0] cmd);
        case (cmd)
            4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return 1'b1;
            default:                                     return 1'b0;
        endcase
    endfunction

    // True for configuration read or write command codes.
    function automatic logic is_cfg_cmd(input logic [3:0] cmd);
        return (cmd == 4'b1010) || (cmd == 4'b1011);
    endfunction

endpackage

// File: rtl/pci_adec_phase.sv
// Module: pci_adec_phase
// Detects the address phase: the edge where FRAME# is sampled low
// while the previous edge saw an idle bus (FRAME# and IRDY# high).
// Assumes a synchronous active-low reset that leaves the bus idle.
module pci_adec_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    output logic addr_phase,
    output logic bus_idle_now
);

    logic idle_prev_q;

    assign bus_idle_now = frame_n & irdy_n;

    // Remember whether the last sampled edge saw an idle bus.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_prev_q <= 1'b1;
        else        idle_prev_q <= bus_idle_now;
    end

    // An address phase needs an idle bus one edge earlier.
    assign addr_phase = idle_prev_q & ~frame_n;

    // R8: a busy bus on one edge forbids an address phase on the next.
    a_r8_busy_blocks_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_n && irdy_n) |=> !addr_phase);

endmodule

// File: rtl/pci_adec_capture.sv
// Module: pci_adec_capture
// Holds the address, command, IDSEL and memory enable sampled in the
// address phase. The values stay put until the next address phase.
// Assumes load is high for exactly the address-phase edge.
module pci_adec_capture #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ad,
    input  logic [CMD_W-1:0]  cbe_n,
    input  logic              idsel,
    input  logic              mem_en,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CMD_W-1:0]  cmd_q,
    output logic              idsel_q,
    output logic              men_q
);

    // Capture the bus fields on the address-phase edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cmd_q   <= '0;
            idsel_q <= 1'b0;
            men_q   <= 1'b0;
        end else if (load) begin
            addr_q  <= ad;
            cmd_q   <= cbe_n;
            idsel_q <= idsel;
            men_q   <= mem_en;
        end
    end

    // R2: the address phase values appear on the next cycle.
    a_r2_capture_on_phase: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_q == $past(ad)) && (cmd_q == $past(cbe_n)));

    // R8: outside an address phase the captured fields do not move.
    a_r8_hold_outside_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_q) && $stable(cmd_q) && $stable(idsel_q) && $stable(men_q));

endmodule

// File: rtl/pci_adec_match.sv
// Module: pci_adec_match
// Combinational decode of the captured address phase: memory window
// match against the BAR and configuration select. Assumes the BAR
// window is naturally aligned, 2**BAR_SIZE_LOG2 bytes in size.
module pci_adec_match
    import pci_adec_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int BAR_SIZE_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [3:0]        cmd_q,
    input  logic              idsel_q,
    input  logic              men_q,
    input  logic [ADDR_W-1:0] bar_base,
    output logic              mem_match,
    output logic              cfg_match
);

    localparam logic [ADDR_W-1:0] LOW_ONES = (ADDR_W'(1) << BAR_SIZE_LOG2) - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] BAR_MASK = ~LOW_ONES;

    logic window_ok;

    // Compare only the bits above the window size.
    generate
        if (BAR_SIZE_LOG2 >= ADDR_W) begin : g_whole_space
            assign window_ok = 1'b1;
        end else begin : g_masked
            assign window_ok = ((addr_q ^ bar_base) & BAR_MASK) == '0;
        end
    endgenerate

    // Memory decode needs a memory command, the enable and the window.
    always_comb begin
        mem_match = is_mem_cmd(cmd_q) & men_q & window_ok;
    end

    // Configuration decode needs IDSEL, a config command and type-0 bits.
    always_comb begin
        cfg_match = idsel_q & is_cfg_cmd(cmd_q) & (addr_q[1:0] == 2'b00);
    end

endmodule

// File: rtl/pci_addr_decoder.sv
// Module: pci_addr_decoder (top)
// Captures the address phase of each PCI transaction and decodes it one
// clock later from the stored copy, so that single-clock FRAME# accesses
// are still claimed. Produces registered hits and a recommendation
// (idle / busy for another agent / claim) for the target controller.
// Assumes bar_base is held stable for the duration of a transaction.
module pci_addr_decoder
    import pci_adec_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int CMD_W         = 4,
    parameter int BAR_SIZE_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              idsel,
    input  logic [ADDR_W-1:0] ad,
    input  logic [CMD_W-1:0]  cbe_n,
    input  logic [ADDR_W-1:0] bar_base,
    input  logic              mem_space_en,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              mem_hit_o,
    output logic              cfg_hit_o,
    output logic [1:0]        rec_o
);

    logic   addr_phase;
    logic   bus_idle_now;
    logic   idsel_q;
    logic   men_q;
    logic   mem_match;
    logic   cfg_match;
    state_e state_q;
    rec_e   rec;

    pci_adec_phase i_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n      (frame_n),
        .irdy_n       (irdy_n),
        .addr_phase   (addr_phase),
        .bus_idle_now (bus_idle_now)
    );

    pci_adec_capture #(
        .ADDR_W (ADDR_W),
        .CMD_W  (CMD_W)
    ) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_phase),
        .ad      (ad),
        .cbe_n   (cbe_n),
        .idsel   (idsel),
        .mem_en  (mem_space_en),
        .addr_q  (addr_o),
        .cmd_q   (cmd_o),
        .idsel_q (idsel_q),
        .men_q   (men_q)
    );

    pci_adec_match #(
        .ADDR_W        (ADDR_W),
        .BAR_SIZE_LOG2 (BAR_SIZE_LOG2)
    ) i_match (
        .addr_q    (addr_o),
        .cmd_q     (cmd_o[3:0]),
        .idsel_q   (idsel_q),
        .men_q     (men_q),
        .bar_base  (bar_base),
        .mem_match (mem_match),
        .cfg_match (cfg_match)
    );

    // Track the transaction and register the decode results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mem_hit_o <= 1'b0;
            cfg_hit_o <= 1'b0;
        end else if (addr_phase) begin
            state_q   <= ST_LATCHED;
            mem_hit_o <= 1'b0;
            cfg_hit_o <= 1'b0;
        end else begin
            case (state_q)
                ST_LATCHED: begin
                    mem_hit_o <= mem_match;
                    cfg_hit_o <= cfg_match;
                    state_q   <= (mem_match || cfg_match) ? ST_CLAIMED : ST_BUSY;
                end
                ST_BUSY, ST_CLAIMED: begin
                    if (bus_idle_now) begin
                        state_q   <= ST_IDLE;
                        mem_hit_o <= 1'b0;
                        cfg_hit_o <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Map the tracking state onto the recommendation code.
    always_comb begin
        case (state_q)
            ST_BUSY:    rec = REC_BUSY;
            ST_CLAIMED: rec = REC_DECODED;
            default:    rec = REC_IDLE;
        endcase
    end

    assign rec_o = rec;

    // R5: no hit is reported while the recommendation is idle.
    a_r5_idle_has_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_o == 2'b00) |-> (!mem_hit_o && !cfg_hit_o));

    // R6: a claim always comes with a hit.
    a_r6_claim_has_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_o == 2'b10) |-> (mem_hit_o || cfg_hit_o));

    // R6: busy never comes with a hit.
    a_r6_busy_has_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_o == 2'b01) |-> (!mem_hit_o && !cfg_hit_o));

    // R7: decode results hold while the bus stays in use.
    a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ((rec_o != 2'b00) && !(frame_n && irdy_n))
        |=> ($stable(mem_hit_o) && $stable(cfg_hit_o) && $stable(rec_o)));

    // R7: an idle bus releases the decode.
    a_r7_release_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((rec_o != 2'b00) && frame_n && irdy_n) |=> (rec_o == 2'b00));

    // R4: memory and configuration hits never coincide.
    a_r4_hits_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_hit_o && cfg_hit_o));

endmodule

// File: tb/test_pci_addr_decoder.sv
// Bench for pci_addr_decoder: directed corner cases plus seeded random
// transactions, checked against expectations computed from the brief.
module test_pci_addr_decoder;

    localparam int BAR_LOG2 = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n, irdy_n, idsel, mem_space_en;
    logic [31:0] ad, bar_base, addr_o;
    logic [3:0]  cbe_n, cmd_o;
    logic        mem_hit_o, cfg_hit_o;
    logic [1:0]  rec_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pci_addr_decoder i_pci_addr_decoder (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .ad(ad), .cbe_n(cbe_n), .bar_base(bar_base),
        .mem_space_en(mem_space_en), .addr_o(addr_o), .cmd_o(cmd_o),
        .mem_hit_o(mem_hit_o), .cfg_hit_o(cfg_hit_o), .rec_o(rec_o)
    );

    // Record one check and report it if it fails.
    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Expected memory hit per the window and command rules.
    function automatic bit exp_mem(input logic [31:0] a, input logic [3:0] c, input bit men, input logic [31:0] bar);
        bit cmd_ok = (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) || (c == 4'b1110) || (c == 4'b1111);
        return cmd_ok && men && ((a >> BAR_LOG2) == (bar >> BAR_LOG2));
    endfunction

    // Expected configuration hit per the select rules.
    function automatic bit exp_cfg(input logic [31:0] a, input logic [3:0] c, input bit ids);
        return ids && ((c == 4'b1010) || (c == 4'b1011)) && (a[1:0] == 2'b00);
    endfunction

    // One complete transaction followed by one idle clock plus gap more.
    task automatic run_txn(input logic [31:0] a, input logic [3:0] c, input bit ids, input bit men,
                           input int ndata, input int gap, input string tag);
        bit em, ec;
        logic [1:0] er;
        em = exp_mem(a, c, men, bar_base);
        ec = exp_cfg(a, c, ids);
        er = (em || ec) ? 2'b10 : 2'b01;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = c; idsel = ids; mem_space_en = men;
        @(negedge clk);
        chk(addr_o == a, {tag, " R2 address captured"}, addr_o, a);
        chk(cmd_o == c, {tag, " R2 command captured"}, {28'd0, cmd_o}, {28'd0, c});
        chk(rec_o == 2'b00 && !mem_hit_o && !cfg_hit_o, {tag, " R5 pending cycle quiet"},
            {29'd0, rec_o, mem_hit_o | cfg_hit_o}, 32'd0);
        for (int i = 1; i <= ndata; i++) begin
            frame_n = (i == ndata); irdy_n = 1'b0;
            ad = $urandom; cbe_n = 4'($urandom); idsel = 1'($urandom); mem_space_en = 1'($urandom);
            @(negedge clk);
            chk(mem_hit_o == em, {tag, " R4 mem_hit"}, {31'd0, mem_hit_o}, {31'd0, em});
            chk(cfg_hit_o == ec, {tag, " R3 cfg_hit"}, {31'd0, cfg_hit_o}, {31'd0, ec});
            chk(rec_o == er, {tag, " R6 recommendation"}, {30'd0, rec_o}, {30'd0, er});
            chk(addr_o == a && cmd_o == c, {tag, " R8 data phase ignored"}, addr_o, a);
        end
        frame_n = 1'b1; irdy_n = 1'b1; ad = $urandom; cbe_n = 4'($urandom); idsel = 1'($urandom);
        @(negedge clk);
        chk(rec_o == 2'b00 && !mem_hit_o && !cfg_hit_o, {tag, " R7 release on idle"},
            {29'd0, rec_o, mem_hit_o | cfg_hit_o}, 32'd0);
        chk(addr_o == a, {tag, " R2 address held"}, addr_o, a);
        repeat (gap) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        logic [3:0] codes [8];
        codes[0] = 4'b0110; codes[1] = 4'b0111; codes[2] = 4'b1100; codes[3] = 4'b1111;
        codes[4] = 4'b1010; codes[5] = 4'b1011; codes[6] = 4'b0010; codes[7] = 4'b1110;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0; ad = '0; cbe_n = '0;
        mem_space_en = 1'b1; bar_base = 32'h4000_0000;
        repeat (3) @(negedge clk);
        chk(rec_o == 2'b00 && !mem_hit_o && !cfg_hit_o && addr_o == 0 && cmd_o == 0,
            "R1 state during reset", {rec_o, mem_hit_o, cfg_hit_o, cmd_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rec_o == 2'b00 && !mem_hit_o && !cfg_hit_o && addr_o == 0,
            "R1 state after reset", {28'd0, rec_o, mem_hit_o, cfg_hit_o}, 32'd0);

        // R9: single-clock FRAME# configuration read with IDSEL high.
        run_txn(32'h0000_0004, 4'b1010, 1'b1, 1'b0, 1, 0, "R9 cfg read one clock");
        // R3: IDSEL low, or non-zero type bits, is not a configuration hit.
        run_txn(32'h0000_0008, 4'b1011, 1'b0, 1'b1, 1, 0, "R3 idsel low");
        run_txn(32'h0000_0009, 4'b1010, 1'b1, 1'b1, 2, 0, "R3 type bits set");
        // R4: enable cleared gives no hit even inside the window.
        run_txn(32'h4000_0010, 4'b0110, 1'b0, 1'b0, 2, 0, "R4 enable clear");
        // R4: window edges.
        run_txn(32'h4000_0FFC, 4'b0111, 1'b0, 1'b1, 1, 0, "R4 window top");
        run_txn(32'h4000_1000, 4'b0111, 1'b0, 1'b1, 1, 0, "R4 above window");
        run_txn(32'h3FFF_FFFC, 4'b1100, 1'b0, 1'b1, 3, 0, "R4 below window");
        run_txn(32'h4000_0000, 4'b0010, 1'b1, 1'b1, 1, 0, "R4 non-memory command");
        // R10: back-to-back with one idle clock, hit then miss then hit.
        run_txn(32'h4000_0100, 4'b1110, 1'b0, 1'b1, 1, 0, "R10 first");
        run_txn(32'h5000_0100, 4'b1110, 1'b0, 1'b1, 1, 0, "R10 second");
        run_txn(32'h0000_0010, 4'b1011, 1'b1, 1'b1, 1, 1, "R10 third");

        // Random transactions with biased window and command choice.
        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            logic [3:0]  c;
            bar_base = {$urandom} & 32'hFFFF_F000;
            c = codes[$urandom_range(0, 7)];
            a = ($urandom_range(0, 1) == 1) ? (bar_base | ($urandom & 32'h0000_0FFF)) : $urandom;
            if ((c == 4'b1010 || c == 4'b1011) && $urandom_range(0, 3) != 0) a[1:0] = 2'b00;
            run_txn(a, c, 1'($urandom), ($urandom_range(0, 4) != 0),
                    $urandom_range(1, 4), $urandom_range(0, 2), "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule